// File: doc/BRIEF.md
# DVMA Table-Walk Address Translator

This block turns a 32-bit device virtual address into a 34-bit physical address. It does so by reading one 64-bit entry from a flat, physically contiguous translation table in memory. Two configuration registers set it up through a small write port: a control word and a table base. The control word holds the enable bit and a 3-bit size code. That code fixes both how large the table is and which region at the top of the 32-bit space forms the translation window.

A device presents an address and a write flag on a valid/ready request port. If translation is off, the address comes straight back. If translation is on, the block first checks that the address lies inside the window. It then issues a single-beat read for the entry, waits for the data strobe, and checks the entry's valid bit and write permission. It answers with either the physical address and its attribute bits, or a fault code. Only one translation is in flight at a time. Only 8 KB pages are handled.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_valid` and `mem_rd_valid` are 0.
- R2: A write with `cfg_wr_sel`=0 loads the enable bit from data bit 0 and the size code from data bits 18:16. A write with `cfg_wr_sel`=1 loads the table base from data bits 33:13; the base's low 13 bits always read as zero.
- R3: With enable clear, the response is `{2'b00, va}` with fault 0 and both attribute bits 0, and no memory read is issued.
- R4: For size code n, the window starts at 0xFF800000 shifted left by n (in 32 bits) and runs to 0xFFFFFFFF. An address below the start gives fault 1, a physical address of 0, and no memory read.
- R5: An in-window address causes exactly one single-cycle `mem_rd_valid` pulse. Its address is base + ((va - window start) >> 13) * 8.
- R6: An entry with bit 63 clear gives fault 2 and a physical address of 0.
- R7: A write request against a valid entry with bit 1 clear gives fault 3. A read request against the same entry succeeds.
- R8: On success, the physical address is entry bits 33:13 followed by va bits 12:0, cacheable is entry bit 4 and streamable is entry bit 60. Entry bits 61, 59 and 40:34 have no effect.
- R9: `req_ready` falls in the cycle after acceptance and stays low until the response has been taken. While `rsp_ready` is low, the response holds stable.
- R10: The response waits for `mem_rd_dvalid`, for any number of cycles, including data that arrives in the cycle the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 selects control word, 1 selects table base |
| cfg_wr_data | input | 64 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_va | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_pa | output | 34 | Physical address (0 on fault) |
| rsp_cacheable | output | 1 | Page is cacheable |
| rsp_stream | output | 1 | Page is streamable |
| rsp_fault | output | 2 | 0 none, 1 outside window, 2 invalid entry, 3 write denied |
| mem_rd_valid | output | 1 | Entry read request pulse |
| mem_rd_addr | output | 34 | Entry byte address |
| mem_rd_data | input | 64 | Returned entry |
| mem_rd_dvalid | input | 1 | Returned entry valid |

## Verification
Directed addresses sit one below, exactly at, and at the very top of the window for size codes 0 and 7. These separate a wrong start computation from a wrong index computation. Forced entries cover each fault code on its own, plus a success entry with the 64K, local and high page-number bits all set, which exposes any use of ignored fields. Random addresses, write flags, memory latencies from zero upward, response back-pressure and periodic reconfiguration check the fetch address and the result against a bench model, under every size code and both enable states.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RANGE   = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_NOWRITE = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;

  localparam int unsigned ENT_VALID_BIT  = 63;
  localparam int unsigned ENT_STREAM_BIT = 60;
  localparam int unsigned ENT_CACHE_BIT  = 4;
  localparam int unsigned ENT_WRITE_BIT  = 1;
endpackage

// File: rtl/dvma_regs.sv
module dvma_regs #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned MADDR_W    = 34,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned EN_BIT     = 0,
  parameter int unsigned CODE_LSB   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               ctl_en,
  output logic [CODE_W-1:0]  ctl_code,
  output logic [MADDR_W-1:0] tbl_base
);
  localparam int unsigned PPN_W = MADDR_W - PAGE_SHIFT;

  logic              en_q, en_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  logic              ctl_we, base_we;
  logic              unused_wr_bits;

  always_comb begin
    ctl_we  = wr_en & ~wr_sel;
    base_we = wr_en & wr_sel;
    en_d    = wr_data[EN_BIT];
    code_d  = wr_data[CODE_LSB +: CODE_W];
    ppn_d   = wr_data[PAGE_SHIFT +: PPN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (ctl_we) begin
      en_q   <= en_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q <= '0;
    end else if (base_we) begin
      ppn_q <= ppn_d;
    end
  end

  assign ctl_en         = en_q;
  assign ctl_code       = code_q;
  assign tbl_base       = {ppn_q, {PAGE_SHIFT{1'b0}}};
  assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/dvma_window.sv
module dvma_window #(
  parameter int unsigned VA_W         = 32,
  parameter int unsigned MADDR_W      = 34,
  parameter int unsigned PAGE_SHIFT   = 13,
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned MIN_WIN_LOG2 = 23,
  parameter int unsigned ENT_LOG2     = 3
) (
  input  logic [VA_W-1:0]    va,
  input  logic [CODE_W-1:0]  code,
  input  logic [MADDR_W-1:0] tbl_base,
  output logic               hit,
  output logic [MADDR_W-1:0] ent_addr
);
  localparam int unsigned SH_W  = $clog2(VA_W) + 1;
  localparam int unsigned IDX_W = VA_W - PAGE_SHIFT;

  logic [SH_W-1:0]  sh;
  logic [VA_W-1:0]  win_start;
  logic [VA_W-1:0]  offset;
  logic [IDX_W-1:0] idx;
  logic             unused_off;

  // The window always ends at the top of the address space; its start
  // moves down by one doubling per size-code step.
  always_comb begin
    sh        = SH_W'(MIN_WIN_LOG2) + SH_W'(code);
    win_start = {VA_W{1'b1}} << sh;
    hit       = (va >= win_start);
    offset    = va - win_start;
    idx       = offset[VA_W-1:PAGE_SHIFT];
    ent_addr  = tbl_base + (MADDR_W'(idx) << ENT_LOG2);
  end

  assign unused_off = ^offset[PAGE_SHIFT-1:0];
endmodule

// File: rtl/dvma_entry_eval.sv
module dvma_entry_eval
  import dvma_pkg::*;
#(
  parameter int unsigned ENT_W      = 64,
  parameter int unsigned PA_W       = 34,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic [ENT_W-1:0]      entry,
  input  logic                  is_write,
  input  logic [PAGE_SHIFT-1:0] page_off,
  output logic [1:0]            fault,
  output logic [PA_W-1:0]       pa,
  output logic                  cacheable,
  output logic                  stream
);
  logic unused_entry;

  always_comb begin
    fault     = FLT_NONE;
    pa        = '0;
    cacheable = 1'b0;
    stream    = 1'b0;
    if (!entry[ENT_VALID_BIT]) begin
      fault = FLT_INVALID;
    end else if (is_write && !entry[ENT_WRITE_BIT]) begin
      fault = FLT_NOWRITE;
    end else begin
      pa        = {entry[PA_W-1:PAGE_SHIFT], page_off};
      cacheable = entry[ENT_CACHE_BIT];
      stream    = entry[ENT_STREAM_BIT];
    end
  end

  assign unused_entry = ^entry;
endmodule

// File: rtl/dvma_walk.sv
module dvma_walk
  import dvma_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 34,
  parameter int unsigned MADDR_W    = 34,
  parameter int unsigned ENT_W      = 64,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_en,
  input  logic               win_hit,
  input  logic [MADDR_W-1:0] ent_addr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_cacheable,
  output logic               rsp_stream,
  output logic [1:0]         rsp_fault,
  output logic               mem_rd_valid,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic [ENT_W-1:0]   mem_rd_data,
  input  logic               mem_rd_dvalid
);
  walk_state_e             state_q, state_d;
  logic                    ld_req, ld_rsp;
  logic [PAGE_SHIFT-1:0]   off_q;
  logic                    wr_q;
  logic [MADDR_W-1:0]      addr_q;
  logic [PA_W-1:0]         pa_q, pa_d;
  logic                    c_q, c_d, s_q, s_d;
  logic [1:0]              flt_q, flt_d;
  logic [1:0]              ev_fault;
  logic [PA_W-1:0]         ev_pa;
  logic                    ev_c, ev_s;

  dvma_entry_eval #(
    .ENT_W(ENT_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_eval (
    .entry(mem_rd_data), .is_write(wr_q), .page_off(off_q),
    .fault(ev_fault), .pa(ev_pa), .cacheable(ev_c), .stream(ev_s)
  );

  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_rsp  = 1'b0;
    pa_d    = '0;
    c_d     = 1'b0;
    s_d     = 1'b0;
    flt_d   = FLT_NONE;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          if (!ctl_en) begin
            state_d = ST_RESP;
            ld_rsp  = 1'b1;
            pa_d    = PA_W'(req_va);
          end else if (!win_hit) begin
            state_d = ST_RESP;
            ld_rsp  = 1'b1;
            flt_d   = FLT_RANGE;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH, ST_WAIT: begin
        if (mem_rd_dvalid) begin
          state_d = ST_RESP;
          ld_rsp  = 1'b1;
          pa_d    = ev_pa;
          c_d     = ev_c;
          s_d     = ev_s;
          flt_d   = ev_fault;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (ld_req) begin
      off_q  <= req_va[PAGE_SHIFT-1:0];
      wr_q   <= req_write;
      addr_q <= ent_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      c_q   <= 1'b0;
      s_q   <= 1'b0;
      flt_q <= FLT_NONE;
    end else if (ld_rsp) begin
      pa_q  <= pa_d;
      c_q   <= c_d;
      s_q   <= s_d;
      flt_q <= flt_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign mem_rd_valid  = (state_q == ST_FETCH);
  assign mem_rd_addr   = addr_q;
  assign rsp_pa        = pa_q;
  assign rsp_cacheable = c_q;
  assign rsp_stream    = s_q;
  assign rsp_fault     = flt_q;

  // R9: an accepted request closes the request port on the next cycle
  a_r9_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9: a pending response does not change until taken
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) &&
      $stable(rsp_fault) && $stable(rsp_cacheable) && $stable(rsp_stream));

  // R5: the entry read is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  // R6: any fault returns a cleared address and no attributes
  a_r6_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != FLT_NONE) |->
      (rsp_pa == '0) && !rsp_cacheable && !rsp_stream);

  // R10: a response after a fetch needs the data strobe in the prior cycle
  a_r10_wait_data: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !rsp_valid && !mem_rd_dvalid |=> !rsp_valid);
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int unsigned VA_W         = 32,
  parameter int unsigned PA_W         = 34,
  parameter int unsigned MADDR_W      = 34,
  parameter int unsigned ENT_W        = 64,
  parameter int unsigned CFG_W        = 64,
  parameter int unsigned PAGE_SHIFT   = 13,
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned MIN_WIN_LOG2 = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic               cfg_wr_sel,
  input  logic [CFG_W-1:0]   cfg_wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_cacheable,
  output logic               rsp_stream,
  output logic [1:0]         rsp_fault,
  output logic               mem_rd_valid,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic [ENT_W-1:0]   mem_rd_data,
  input  logic               mem_rd_dvalid
);
  localparam int unsigned ENT_LOG2 = $clog2(ENT_W / 8);

  logic               rst_meta_n, rst_sync_n;
  logic               ctl_en;
  logic [CODE_W-1:0]  ctl_code;
  logic [MADDR_W-1:0] tbl_base;
  logic               win_hit;
  logic [MADDR_W-1:0] ent_addr;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  dvma_regs #(
    .DATA_W(CFG_W), .MADDR_W(MADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .CODE_W(CODE_W),
    .EN_BIT(0), .CODE_LSB(16)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .ctl_en(ctl_en), .ctl_code(ctl_code), .tbl_base(tbl_base)
  );

  dvma_window #(
    .VA_W(VA_W), .MADDR_W(MADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .CODE_W(CODE_W),
    .MIN_WIN_LOG2(MIN_WIN_LOG2), .ENT_LOG2(ENT_LOG2)
  ) u_win (
    .va(req_va), .code(ctl_code), .tbl_base(tbl_base),
    .hit(win_hit), .ent_addr(ent_addr)
  );

  dvma_walk #(
    .VA_W(VA_W), .PA_W(PA_W), .MADDR_W(MADDR_W), .ENT_W(ENT_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_walk (
    .clk(clk), .rst_n(rst_sync_n), .ctl_en(ctl_en), .win_hit(win_hit),
    .ent_addr(ent_addr), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable),
    .rsp_stream(rsp_stream), .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_rd_dvalid(mem_rd_dvalid)
  );

  // R5: every entry read is aligned to the entry size
  a_r5_aligned_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_rd_valid |-> (mem_rd_addr[ENT_LOG2-1:0] == '0));

  // R1: no response and no read can appear without a request being taken
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready && !req_valid |=> req_ready && !rsp_valid && !mem_rd_valid);
endmodule

// File: tb/sim_dvma_xlate.sv
module sim_dvma_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
  logic [63:0] cfg_wr_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_cacheable, rsp_stream, mem_rd_valid;
  logic [33:0] rsp_pa, mem_rd_addr;
  logic [1:0]  rsp_fault;
  logic [63:0] mem_rd_data = '0;
  logic        mem_rd_dvalid = 1'b0;

  int nchk = 0, nerr = 0;
  bit          m_en = 1'b0;
  logic [2:0]  m_code = '0;
  logic [33:0] m_base = '0;
  bit          force_en = 1'b0;
  logic [63:0] force_ent = '0;

  always #4 clk = ~clk;

  dvma_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable),
    .rsp_stream(rsp_stream), .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_rd_dvalid(mem_rd_dvalid)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] ent_of(input logic [33:0] a);
    logic [63:0] h;
    h = {30'h0, a} * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 29);
    return force_en ? force_ent : h;
  endfunction

  task automatic cfg(input bit sel, input logic [63:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (!sel) begin m_en = d[0]; m_code = d[18:16]; end
    else m_base = {d[33:13], 13'h0};
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr, input int lat, input int hold);
    logic [31:0] ws;
    bit          hit, exp_read, seen;
    logic [33:0] e_addr, e_pa, h_pa;
    logic [63:0] ent;
    logic [1:0]  e_flt, h_flt;
    bit          e_c, e_s;
    string       rq;
    int          n;
    ws = 32'hFF800000 << m_code;
    hit = (va >= ws);
    e_addr = m_base + ({2'b0, (va - ws) >> 13} << 3);
    exp_read = 1'b0; e_pa = '0; e_flt = 2'd0; e_c = 1'b0; e_s = 1'b0;
    if (!m_en) begin
      e_pa = {2'b00, va}; rq = "R3";
    end else if (!hit) begin
      e_flt = 2'd1; rq = "R4";
    end else begin
      exp_read = 1'b1;
      ent = ent_of(e_addr);
      if (!ent[63]) begin e_flt = 2'd2; rq = "R6"; end
      else if (wr && !ent[1]) begin e_flt = 2'd3; rq = "R7"; end
      else begin
        e_pa = {ent[33:13], va[12:0]}; e_c = ent[4]; e_s = ent[60]; rq = "R8";
      end
    end
    @(negedge clk);
    chk(req_ready, "R9", {63'h0, req_ready}, 64'h1);
    req_va = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", {63'h0, req_ready}, 64'h0);
    seen = 1'b0; n = 0;
    while (!rsp_valid && n < 300) begin
      if (mem_rd_valid) begin
        seen = 1'b1;
        chk(mem_rd_addr == e_addr, "R5", {30'h0, mem_rd_addr}, {30'h0, e_addr});
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          chk(!rsp_valid && !mem_rd_valid, "R10", {63'h0, rsp_valid}, 64'h0);
        end
        mem_rd_data = ent_of(e_addr); mem_rd_dvalid = 1'b1;
        @(negedge clk);
        mem_rd_dvalid = 1'b0; mem_rd_data = {$urandom, $urandom};
      end else begin
        @(negedge clk);
        n++;
      end
    end
    chk(rsp_valid, "R9", {63'h0, rsp_valid}, 64'h1);
    chk(seen == exp_read, exp_read ? "R5" : (m_en ? "R4" : "R3"), {63'h0, seen}, {63'h0, exp_read});
    chk(rsp_fault == e_flt, rq, {62'h0, rsp_fault}, {62'h0, e_flt});
    chk(rsp_pa == e_pa, rq, {30'h0, rsp_pa}, {30'h0, e_pa});
    chk({rsp_cacheable, rsp_stream} == {e_c, e_s}, rq, {62'h0, rsp_cacheable, rsp_stream}, {62'h0, e_c, e_s});
    h_pa = rsp_pa; h_flt = rsp_fault;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_pa == h_pa && rsp_fault == h_flt, "R9",
          {30'h0, rsp_pa}, {30'h0, h_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9", {62'h0, rsp_valid, req_ready}, 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1",
        {61'h0, req_ready, rsp_valid, mem_rd_valid}, 64'h4);

    // R3 pass-through while disabled, window ignored
    xlate(32'h1234_5678, 1'b0, 0, 0);
    xlate(32'hFFFF_FFFF, 1'b1, 0, 1);

    // R2 base low bits dropped; R4/R5 window edges for code 0
    cfg(1'b1, 64'h0000_0002_0000_1FFF);
    cfg(1'b0, 64'h0000_0000_0000_0001);
    xlate(32'hFF80_0000, 1'b0, 1, 0);
    xlate(32'hFF7F_FFFF, 1'b0, 1, 0);
    xlate(32'hFFFF_FFFF, 1'b0, 2, 0);

    // R2 size code field; R4 edges for code 7
    cfg(1'b0, 64'h0000_0000_0007_0001);
    xlate(32'hC000_0000, 1'b0, 0, 0);
    xlate(32'hBFFF_FFFF, 1'b1, 0, 0);
    xlate(32'hE123_4567, 1'b0, 3, 0);

    // R6 invalid entry, write bit set
    force_en = 1'b1;
    force_ent = 64'h7FFF_FFFF_FFFF_FFFF;
    xlate(32'hD000_0010, 1'b0, 1, 0);
    // R7 valid entry without write permission
    force_ent = 64'h8000_0000_1234_6011;
    xlate(32'hD000_0020, 1'b1, 1, 0);
    xlate(32'hD000_0020, 1'b0, 1, 0);
    // R8 ignored fields: 64K, local and high page bits set
    force_ent = 64'hB800_01FF_FFFF_E012;
    xlate(32'hD000_1ABC, 1'b1, 0, 0);
    // R9/R10 long latency and held response
    xlate(32'hD000_3ABC, 1'b0, 25, 4);
    force_en = 1'b0;

    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      if (i % 25 == 0) begin
        cfg(1'b1, {$urandom, $urandom});
        cfg(1'b0, {45'h0, 3'($urandom), 15'($urandom), ($urandom % 8) != 0});
      end
      va = $urandom;
      if ($urandom % 2) va[31:30] = 2'b11;
      xlate(va, 1'($urandom), int'($urandom % 6), int'($urandom % 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule